// File: doc/BRIEF.md
# Nested-Virtualization System-Register Access Redirector

This block owns one 64-bit base-address register and steers each system-register access aimed at it. Every accepted request is placed in exactly one of four classes, chosen from the requester's privilege level (0 to 3) and the hypervisor control inputs:

- **Direct:** the register itself is read or written.
- **Redirect:** the access becomes a memory load or store at a sign-extended base-plus-offset address.
- **Trap:** the access is reported as a trap to level 2 with a syndrome class code.
- **Undefined:** the access is flagged as undefined.

A redirected access holds a memory request open until the memory side acknowledges it. While that request is open, new requests are dropped. A redirected read returns the memory data to the requester one cycle after the acknowledge.

The stored register keeps the raw upper bits that software wrote. Bits [11:0] are always zero. For address formation only, the upper bits are replaced by copies of the top base bit:

- bit 52 when the wide virtual-address mode is on;
- bit 48 when it is off.

Top module: `sysreg_redirect`

## Requirements
- R1: A request from level 0 raises `outUndef` and no other status output.
- R2: A level-1 request with `hypEnable`, `nvBit` and `nv2Bit` all 1 raises `outRedirect` and opens a memory request. A read opens a load (`memReqWrite`=0) and a write opens a store (`memReqWrite`=1) carrying `reqWdata`. The address has bits [11:0] = 0x0B0.
- R3: A level-1 request with `hypEnable`=1, `nvBit`=1 and `nv2Bit`=0 raises `outTrap` with `trapClass`=0x18. `trapClass` is 0 in every cycle without a trap pulse.
- R4: Every other level-1 request raises `outUndef`. This covers the hypervisor being disabled and `nvBit`=0.
- R5: A request from level 2 or 3 raises `outDirect`. A write updates the register. A read pulses `rspValid` in the same cycle as `outDirect`, carrying the register's value.
- R6: Bits [11:0] of the register always read as zero, whatever value was written.
- R7: With `wideVa`=1, the memory address is {11 copies of register bit 52, register bits [52:12], 0x0B0}.
- R8: With `wideVa`=0, the memory address is {15 copies of register bit 48, register bits [48:12], 0x0B0}.
- R9: A direct read returns the raw stored bits [63:53], even when they are not all equal.
- R10: Each accepted request produces exactly one one-hot status pulse, in the cycle after it is accepted. Status outputs are never active together.
- R11: `memReqValid`, `memAddr`, `memWdata` and `memReqWrite` stay stable until `memAck` is seen. Requests that arrive while `memReqValid` is high are dropped: they produce no status pulse and no register change.
- R12: After `memAck` on a load, `rspValid` pulses in the following cycle with `rspRdata` equal to `memRdata`. A store produces no `rspValid`.
- R13: After reset the register is zero and all status, memory and response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLevel | input | 2 | Requester privilege level |
| reqWdata | input | 64 | Write data |
| hypEnable | input | 1 | Hypervisor enabled in current security state |
| nvBit | input | 1 | Nested-virtualization trap control |
| nv2Bit | input | 1 | Nested-virtualization memory-redirect control |
| wideVa | input | 1 | Level-2 address space wider than 48 bits |
| memReqValid | output | 1 | Memory request open |
| memReqWrite | output | 1 | Memory request is a store |
| memAddr | output | 64 | Memory request address |
| memWdata | output | 64 | Store data |
| memAck | input | 1 | Memory request acknowledge |
| memRdata | input | 64 | Load return data, valid with memAck |
| rspValid | output | 1 | Read data valid to requester |
| rspRdata | output | 64 | Read data to requester |
| outDirect | output | 1 | Direct-access status pulse |
| outRedirect | output | 1 | Redirect status pulse |
| outTrap | output | 1 | Trap status pulse |
| outUndef | output | 1 | Undefined status pulse |
| trapClass | output | 6 | Syndrome class, valid with outTrap |

## Verification
The bench walks the level and control-bit combinations one at a time, including `nv2Bit` alone and the hypervisor being disabled. A design that tested the trap path before the redirect path, or that ignored `hypEnable`, would raise the wrong status pulse for those vectors.

It writes base values whose upper bits disagree with bits 52 and 48 and forms addresses in both address-width modes. A design that sign-extended from the wrong bit, or that normalised the stored copy, would show a wrong `memAddr` or a wrong read-back.

It also sends a write while a memory request is still unacknowledged, and then reads the register. A design that did not drop that write would pulse a status output or change the register.

Finally it checks that store acknowledges produce no response. A design that returned data on every acknowledge would pulse `rspValid` there.

// File: rtl/sysreg_redirect_pkg.sv
package sysreg_redirect_pkg;

  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'd0,
    ACC_REDIRECT = 2'd1,
    ACC_TRAP     = 2'd2,
    ACC_UNDEF    = 2'd3
  } accKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic regWrite;   // update base register
    logic rspDirect;  // return base register to requester
    logic memLaunch;  // capture address and store data
    logic rspMem;     // return memory data to requester
  } dpStrobe_t;

  // Redirect is examined before trap
  function automatic accKind_e classifyAccess(input logic [1:0] lvl,
                                              input logic hyp,
                                              input logic nv,
                                              input logic nv2);
    accKind_e k;
    if (lvl == 2'd0)                 k = ACC_UNDEF;
    else if (lvl != 2'd1)            k = ACC_DIRECT;
    else if (hyp && nv && nv2)       k = ACC_REDIRECT;
    else if (hyp && nv)              k = ACC_TRAP;
    else                             k = ACC_UNDEF;
    return k;
  endfunction

endpackage

// File: rtl/sysreg_redirect_ctrl.sv
module sysreg_redirect_ctrl
  import sysreg_redirect_pkg::*;
#(
  parameter int unsigned CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CODE = 6'h18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [1:0]         reqLevel,
  input  logic               hypEnable,
  input  logic               nvBit,
  input  logic               nv2Bit,
  input  logic               memAck,
  output dpStrobe_t          strobe,
  output logic               memPending,
  output logic               memIsWrite,
  output logic               stDirect,
  output logic               stRedirect,
  output logic               stTrap,
  output logic               stUndef,
  output logic [CLASS_W-1:0] stClass
);

  logic     accept;
  logic     memDone;
  accKind_e kind;

  always_comb begin
    accept  = reqValid && !memPending;
    kind    = classifyAccess(reqLevel, hypEnable, nvBit, nv2Bit);
    memDone = memPending && memAck;

    strobe.regWrite  = accept && (kind == ACC_DIRECT) && reqWrite;
    strobe.rspDirect = accept && (kind == ACC_DIRECT) && !reqWrite;
    strobe.memLaunch = accept && (kind == ACC_REDIRECT);
    strobe.rspMem    = memDone && !memIsWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memPending <= 1'b0;
      memIsWrite <= 1'b0;
    end else if (strobe.memLaunch) begin
      memPending <= 1'b1;
      memIsWrite <= reqWrite;
    end else if (memDone) begin
      memPending <= 1'b0;
      memIsWrite <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stDirect   <= 1'b0;
      stRedirect <= 1'b0;
      stTrap     <= 1'b0;
      stUndef    <= 1'b0;
      stClass    <= '0;
    end else begin
      stDirect   <= accept && (kind == ACC_DIRECT);
      stRedirect <= accept && (kind == ACC_REDIRECT);
      stTrap     <= accept && (kind == ACC_TRAP);
      stUndef    <= accept && (kind == ACC_UNDEF);
      stClass    <= (accept && (kind == ACC_TRAP)) ? TRAP_CODE : '0;
    end
  end

endmodule

// File: rtl/sysreg_redirect_dp.sv
module sysreg_redirect_dp
  import sysreg_redirect_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned LOW_W    = 12,
  parameter int unsigned WIDE_TOP = 52,
  parameter int unsigned NARR_TOP = 48,
  parameter logic [LOW_W-1:0] SLOT_OFFSET = 12'h0B0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              wideVa,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((64'd1 << LOW_W) - 64'd1);

  logic [DATA_W-1:0] baseReg;
  logic [DATA_W-1:0] effAddr;

  // Sign-extend from the selected top bit; stored bits stay raw
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      if (i < LOW_W)
        effAddr[i] = SLOT_OFFSET[i];
      else if (wideVa)
        effAddr[i] = (i <= WIDE_TOP) ? baseReg[i] : baseReg[WIDE_TOP];
      else
        effAddr[i] = (i <= NARR_TOP) ? baseReg[i] : baseReg[NARR_TOP];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      baseReg <= '0;
    else if (strobe.regWrite)
      baseReg <= reqWdata & ~LOW_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memWdata <= '0;
    end else if (strobe.memLaunch) begin
      memAddr  <= effAddr;
      memWdata <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobe.rspDirect || strobe.rspMem;
      if (strobe.rspDirect)
        rspRdata <= baseReg;
      else if (strobe.rspMem)
        rspRdata <= memRdata;
    end
  end

endmodule

// File: rtl/sysreg_redirect.sv
module sysreg_redirect
  import sysreg_redirect_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned CLASS_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [1:0]         reqLevel,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic               hypEnable,
  input  logic               nvBit,
  input  logic               nv2Bit,
  input  logic               wideVa,
  output logic               memReqValid,
  output logic               memReqWrite,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic               memAck,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspRdata,
  output logic               outDirect,
  output logic               outRedirect,
  output logic               outTrap,
  output logic               outUndef,
  output logic [CLASS_W-1:0] trapClass
);

  dpStrobe_t strobe;

  sysreg_redirect_ctrl #(.CLASS_W(CLASS_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqLevel(reqLevel),
    .hypEnable(hypEnable), .nvBit(nvBit), .nv2Bit(nv2Bit),
    .memAck(memAck), .strobe(strobe),
    .memPending(memReqValid), .memIsWrite(memReqWrite),
    .stDirect(outDirect), .stRedirect(outRedirect),
    .stTrap(outTrap), .stUndef(outUndef), .stClass(trapClass)
  );

  sysreg_redirect_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWdata(reqWdata), .wideVa(wideVa), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );

endmodule

// File: rtl/sysreg_redirect_chk.sv
module sysreg_redirect_chk #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned CLASS_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqWrite,
  input logic [1:0]         reqLevel,
  input logic               memReqValid,
  input logic               memReqWrite,
  input logic [DATA_W-1:0]  memAddr,
  input logic [DATA_W-1:0]  memWdata,
  input logic               memAck,
  input logic               rspValid,
  input logic [DATA_W-1:0]  rspRdata,
  input logic               outDirect,
  input logic               outRedirect,
  input logic               outTrap,
  input logic               outUndef,
  input logic [CLASS_W-1:0] trapClass
);

  assert_level0_undef_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !memReqValid && reqLevel == 2'd0 |=> outUndef);

  assert_slot_offset_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memAddr[11:0] == 12'h0B0);

  assert_trap_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    outTrap |-> trapClass == 6'h18);

  assert_class_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !outTrap |-> trapClass == '0);

  assert_direct_read_low_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    outDirect && rspValid |-> rspRdata[11:0] == 12'h000);

  assert_status_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outDirect, outRedirect, outTrap, outUndef}));

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memAck |=> memReqValid && $stable(memAddr)
                               && $stable(memWdata) && $stable(memReqWrite));

  assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memAck |=> !outDirect && !outRedirect && !outTrap && !outUndef);

  assert_load_return_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memAck && !memReqWrite |=> rspValid);

  assert_store_silent_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memAck && memReqWrite |=> !rspValid);

endmodule

bind sysreg_redirect sysreg_redirect_chk #(.DATA_W(DATA_W), .CLASS_W(CLASS_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqLevel(reqLevel), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
  .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
  .rspValid(rspValid), .rspRdata(rspRdata), .outDirect(outDirect),
  .outRedirect(outRedirect), .outTrap(outTrap), .outUndef(outUndef),
  .trapClass(trapClass)
);

// File: tb/sysreg_redirect_bench.sv
module sysreg_redirect_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqLevel = 2'd0;
  logic [63:0] reqWdata = '0;
  logic        hypEnable = 1'b0, nvBit = 1'b0, nv2Bit = 1'b0, wideVa = 1'b0;
  logic        memReqValid, memReqWrite;
  logic [63:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [63:0] memRdata = '0;
  logic        rspValid;
  logic [63:0] rspRdata;
  logic        outDirect, outRedirect, outTrap, outUndef;
  logic [5:0]  trapClass;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  sysreg_redirect u_sysreg_redirect (.*);

  // {write, level[1:0], hyp, nv, nv2, kind[1:0]}; kind 0 direct 1 redirect 2 trap 3 undef
  localparam logic [7:0] VEC [12] = '{
    {1'b0, 2'd0, 3'b111, 2'd3},
    {1'b1, 2'd0, 3'b000, 2'd3},
    {1'b0, 2'd1, 3'b111, 2'd1},
    {1'b1, 2'd1, 3'b111, 2'd1},
    {1'b0, 2'd1, 3'b110, 2'd2},
    {1'b1, 2'd1, 3'b110, 2'd2},
    {1'b0, 2'd1, 3'b011, 2'd3},
    {1'b0, 2'd1, 3'b101, 2'd3},
    {1'b1, 2'd1, 3'b100, 2'd3},
    {1'b0, 2'd2, 3'b000, 2'd0},
    {1'b1, 2'd3, 3'b111, 2'd0},
    {1'b0, 2'd3, 3'b010, 2'd0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Drive one request; returns at the negedge after the accepting edge
  task automatic issue(input logic w, input logic [1:0] lvl, input logic [2:0] ctl,
                       input logic [63:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqLevel = lvl; reqWdata = d;
    {hypEnable, nvBit, nv2Bit} = ctl;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Acknowledge the open memory request; returns one cycle after ack edge
  task automatic ackMem(input logic [63:0] rd);
    memAck = 1'b1; memRdata = rd;
    @(negedge clk);
    memAck = 1'b0;
  endtask

  function automatic logic [63:0] expAddr(input logic [63:0] b, input logic wide);
    if (wide) return {{11{b[52]}}, b[52:12], 12'h0B0};
    return {{15{b[48]}}, b[48:12], 12'h0B0};
  endfunction

  task automatic directRead(input string req, input logic [63:0] exp);
    issue(1'b0, 2'd2, 3'b000, 64'h0);
    check({req, " direct read valid"}, {63'b0, rspValid}, 64'd1);
    check({req, " direct read data"}, rspRdata, exp);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=expired expected=done");
    endRun();
  end

  initial begin : main
    logic [3:0] st;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 status", {60'b0, outDirect, outRedirect, outTrap, outUndef}, 64'h0);
    check("R13 mem/rsp", {62'b0, memReqValid, rspValid}, 64'h0);
    rstN = 1'b1;
    directRead("R13", 64'h0);

    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      logic [63:0] d;
      v = VEC[i];
      d = 64'h0000_1234_5678_9000 + 64'(i) * 64'h1000;
      issue(v[7], v[6:5], v[4:2], d);
      st = 4'b0;
      st[v[1:0]] = 1'b1;
      check("R10 one-hot status R1 R2 R3 R4 R5",
            {60'b0, outUndef, outTrap, outRedirect, outDirect}, {60'b0, st});
      check("R3 trap class", {58'b0, trapClass}, (v[1:0] == 2'd2) ? 64'h18 : 64'h0);
      if (v[1:0] == 2'd0 && !v[7])
        check("R5 read response", {63'b0, rspValid}, 64'd1);
      if (v[1:0] == 2'd1) begin
        check("R2 mem open", {62'b0, memReqValid, memReqWrite}, {62'b0, 1'b1, v[7]});
        check("R2 offset", {52'b0, memAddr[11:0]}, 64'h0B0);
        if (v[7]) check("R2 store data", memWdata, d);
        ackMem(64'hA5A5_0000_0000_0000 | 64'(i));
        check("R12 response after ack", {63'b0, rspValid}, {63'b0, !v[7]});
        if (!v[7]) check("R12 load data", rspRdata, 64'hA5A5_0000_0000_0000 | 64'(i));
        check("R11 request closed", {63'b0, memReqValid}, 64'h0);
      end
    end

    // R6 low bits forced to zero
    issue(1'b1, 2'd3, 3'b000, 64'hFFFF_FFFF_FFFF_FFFF);
    directRead("R6", 64'hFFFF_FFFF_FFFF_F000);

    // R9 raw readback with inconsistent upper bits; R7 and R8 addresses
    issue(1'b1, 2'd2, 3'b000, 64'h0010_0000_1234_5ABC);
    directRead("R9", 64'h0010_0000_1234_5000);
    wideVa = 1'b1;
    issue(1'b0, 2'd1, 3'b111, 64'h0);
    check("R7 wide address", memAddr, expAddr(64'h0010_0000_1234_5000, 1'b1));
    check("R7 wide literal", memAddr, 64'hFFF0_0000_1234_50B0);
    ackMem(64'h0);
    wideVa = 1'b0;
    issue(1'b0, 2'd1, 3'b111, 64'h0);
    check("R8 narrow address", memAddr, 64'h0000_0000_1234_50B0);
    ackMem(64'h0);

    issue(1'b1, 2'd3, 3'b000, 64'h0001_8000_0000_0000);
    issue(1'b0, 2'd1, 3'b111, 64'h0);
    check("R8 narrow negative", memAddr, 64'hFFFF_8000_0000_00B0);
    ackMem(64'h0);
    wideVa = 1'b1;
    issue(1'b1, 2'd1, 3'b111, 64'hCAFE_F00D_0000_0001);
    check("R7 wide positive", memAddr, 64'h0001_8000_0000_00B0);

    // R11 hold while unacknowledged; requests dropped while busy
    wideVa = 1'b0;
    issue(1'b1, 2'd2, 3'b000, 64'h1111_2222_3333_4000);
    check("R11 dropped status", {60'b0, outDirect, outRedirect, outTrap, outUndef}, 64'h0);
    check("R11 address held", memAddr, 64'h0001_8000_0000_00B0);
    check("R11 store data held", memWdata, 64'hCAFE_F00D_0000_0001);
    check("R11 still open", {63'b0, memReqValid}, 64'd1);
    ackMem(64'h0);
    check("R12 store no response", {63'b0, rspValid}, 64'h0);
    directRead("R11 register unchanged", 64'h0001_8000_0000_0000);

    endRun();
  end

endmodule